// File: doc/BRIEF.md
# Aging Counter Replacement Tracker

This block tracks how recently each of a set of page frames has been used, to choose which frame to reclaim. Each frame has an age counter of a fixed width and a single "used this period" flag. A reference to a frame raises its flag. A periodic tick moves every counter one place toward the least significant bit. On the same tick the frame's flag enters as the new top bit, and then the flag is cleared. A frame that is in use often therefore keeps a large counter. A frame that has been idle for a while decays toward zero.

When a frame is refilled with a new page, its counter is zeroed and its flag is raised, so that the next tick treats it as just used. To choose a frame to reclaim, software pulses the search request. The block then scans the frames one per cycle and returns the index of the frame with the smallest counter, together with a one-cycle done pulse.

Top module: `aging_victim_tracker`

## Requirements
- R1: After reset every counter and every flag is zero, `find_busy` and `find_done` are low, and a search started right after reset returns frame 0.
- R2: A cycle with `ref_valid` high and no tick raises the flag of frame `ref_frame`. Other frames are unchanged.
- R3: On a cycle with `tick` high, each frame not being loaded gets a new counter equal to its old counter shifted right by one, with the old flag as the most significant bit. Without a tick, counters hold their value.
- R4: After a tick, the flag of every frame is zero, unless R5 or R6 applies to that frame.
- R5: A reference in the same cycle as a tick leaves the referenced frame's flag set for the next period.
- R6: `load_valid` zeroes the counter of frame `load_frame` and sets its flag. This takes priority over a tick or a reference to the same frame in that cycle.
- R7: The reported `victim` is the frame with the smallest counter. When several frames share that value, the lowest-numbered of them is reported.
- R8: A `find_req` accepted while idle raises `find_busy`. After exactly NUM_FRAMES further cycles, `find_done` is high for one cycle with `victim` valid, and `find_busy` is then low.
- R9: `find_req` while `find_busy` is high is ignored. It produces no extra done pulse and does not restart the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| tick | input | 1 | Aging period boundary |
| load_valid | input | 1 | A frame receives a new page this cycle |
| load_frame | input | IDX_W | Index of the frame being loaded |
| find_req | input | 1 | Start a victim search |
| find_busy | output | 1 | A search is in progress |
| find_done | output | 1 | One-cycle pulse: `victim` is valid |
| victim | output | IDX_W | Index of the frame with the smallest counter |

## Verification
On every cycle, assertions check each frame's update: the shift-and-insert on a tick, the flag clear or keep, load priority, and that counters hold between ticks. They also check that the done pulse lasts one cycle and closes a busy period. Whether the reported frame really holds the minimum counter, and whether ties go to the lowest index, can only be seen from the bench scenarios. The bench compares each search result against a reference model after long mixed sequences of references, ticks and loads.

// File: rtl/aging_victim_tracker.sv
module aging_victim_tracker #(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 8,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             tick,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_frame,
  input  logic             find_req,
  output logic             find_busy,
  output logic             find_done,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [AGE_W-1:0]      age_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] refb_q;
  logic [NUM_FRAMES-1:0] ref_hit, load_hit;

  logic             busy_q, done_q;
  logic [IDX_W-1:0] scan_q, best_idx_q, victim_q;
  logic [AGE_W-1:0] best_val_q;
  logic             take;

  always_comb begin
    for (int i = 0; i < NUM_FRAMES; i++) begin
      ref_hit[i]  = ref_valid  && (ref_frame  == IDX_W'(i));
      load_hit[i] = load_valid && (load_frame == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FRAMES; i++) age_q[i] <= '0;
      refb_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (load_hit[i]) begin
          age_q[i]  <= '0;
          refb_q[i] <= 1'b1;
        end else if (tick) begin
          age_q[i]  <= {refb_q[i], age_q[i][AGE_W-1:1]};
          refb_q[i] <= ref_hit[i];
        end else if (ref_hit[i]) begin
          refb_q[i] <= 1'b1;
        end
      end
    end
  end

  assign take = (scan_q == '0) || (age_q[scan_q] < best_val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      scan_q     <= '0;
      best_idx_q <= '0;
      best_val_q <= '0;
      victim_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (find_req) begin
          busy_q <= 1'b1;
          scan_q <= '0;
        end
      end else begin
        if (take) begin
          best_idx_q <= scan_q;
          best_val_q <= age_q[scan_q];
        end
        if (scan_q == LAST) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          victim_q <= take ? scan_q : best_idx_q;
        end else begin
          scan_q <= scan_q + 1'b1;
        end
      end
    end
  end

  assign find_busy = busy_q;
  assign find_done = done_q;
  assign victim    = victim_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    find_done |=> !find_done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    find_done |-> ($past(find_busy) && !find_busy)); // R8
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (find_busy && scan_q != LAST) |=> find_busy); // R9

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
    AST_TICK_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_hit[g]) |=> age_q[g][AGE_W-1] == $past(refb_q[g])); // R3
    AST_TICK_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_hit[g]) |=> age_q[g][AGE_W-2:0] == $past(age_q[g][AGE_W-1:1])); // R3
    AST_AGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_hit[g]) |=> $stable(age_q[g])); // R3
    AST_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit[g] && !tick) |=> refb_q[g]); // R2
    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ref_hit[g] && !load_hit[g]) |=> !refb_q[g]); // R4
    AST_TICK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ref_hit[g]) |=> refb_q[g]); // R5
    AST_LOAD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      load_hit[g] |=> (age_q[g] == '0 && refb_q[g])); // R6
  end

endmodule

// File: tb/aging_victim_tracker_tb.sv
module aging_victim_tracker_tb;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, tick = 0, load_valid = 0, find_req = 0;
  logic [IW-1:0] ref_frame = '0, load_frame = '0;
  logic find_busy, find_done;
  logic [IW-1:0] victim;

  int checks = 0, fails = 0;
  logic [W-1:0] m_age [N];
  logic         m_ref [N];
  logic [15:0]  lfsr = 16'hACE1;

  always #5 clk = ~clk;

  aging_victim_tracker #(.NUM_FRAMES(N), .AGE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .tick(tick), .load_valid(load_valid), .load_frame(load_frame),
    .find_req(find_req), .find_busy(find_busy), .find_done(find_done),
    .victim(victim));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic rv, input int rf, input logic tk, input logic lv, input int lf);
    @(negedge clk);
    ref_valid = rv; ref_frame = IW'(rf); tick = tk; load_valid = lv; load_frame = IW'(lf);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (lv && lf == i) begin m_age[i] = '0; m_ref[i] = 1'b1; end
      else if (tk) begin m_age[i] = {m_ref[i], m_age[i][W-1:1]}; m_ref[i] = rv && rf == i; end
      else if (rv && rf == i) m_ref[i] = 1'b1;
    end
    @(negedge clk);
    ref_valid = 0; tick = 0; load_valid = 0;
  endtask

  function automatic int model_min();
    int b = 0;
    for (int i = 1; i < N; i++) if (m_age[i] < m_age[b]) b = i;
    return b;
  endfunction

  task automatic search(input string req, input logic poke);
    int cyc = 0, dones = 0;
    @(negedge clk);
    find_req = 1;
    @(posedge clk);
    @(negedge clk);
    find_req = poke;
    chk("R8 busy after request", int'(find_busy), 1);
    while (cyc < 50) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (find_done) break;
    end
    find_req = 0;
    chk("R8 cycles to done", cyc, N);
    chk(req, int'(victim), model_min());
    chk("R8 busy low at done", int'(find_busy), 0);
    for (int k = 0; k < N + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (find_done) dones++;
    end
    chk("R9 no extra done pulse", dones, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_age[i] = '0; m_ref[i] = 0; end
    #1;
    chk("R1 busy at reset", int'(find_busy), 0);
    chk("R1 done at reset", int'(find_done), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    search("R1 victim after reset", 0);

    // R7 tie: frame 0 aged up, frames 1..3 tie at zero -> frame 1
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    search("R7 tie lowest index", 0);
    chk("R2 R3 referenced frame not victim", int'(victim), 1);

    // R5: reference with tick keeps flag; second tick puts it in MSB
    step(1, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    search("R5 ref on tick carried", 0);
    chk("R5 victim frame 2", int'(victim), 2);

    // R4: flags cleared -> no new bits on following ticks
    step(0, 0, 1, 0, 0);
    search("R4 flags cleared", 0);

    // R6: load with tick and ref on same frame
    step(1, 0, 1, 1, 0);
    search("R6 load priority", 0);
    step(0, 0, 1, 0, 0);
    search("R6 loaded frame flag set", 0);

    // R9: request held during busy
    search("R9 request while busy", 1);

    // R3 R7 sweep with pseudo-random stimulus
    for (int it = 0; it < 400; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[2:1]), lfsr[5:3] == 3'd0, lfsr[9:6] == 4'd0, int'(lfsr[11:10]));
      if (it % 7 == 6) search("R7 minimum after mixed history", 0);
    end
    // R3 decay to all-zero: ties resolve to frame 0
    for (int k = 0; k < W + 1; k++) step(0, 0, 1, 0, 0);
    search("R3 full decay", 0);
    chk("R3 R7 decayed victim frame 0", int'(victim), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule